// File: doc/BRIEF.md
# NAND Page Buffer and Array Engine

This block is the storage back end of a NAND flash model. It holds a small on-chip array of pages, and each page is followed by a spare area. A command sequencer in front of it sends one-cycle operation pulses together with a page number, a column and a column offset. The block then streams page bytes out through a byte-wide read port, collects program data in a page buffer, and commits that buffer into the array. It also erases whole blocks.

The block follows NAND rules. A program can only clear bits, because each buffer byte is ANDed into the byte already stored in the array. An erase sets every data byte and every spare byte of an aligned block to 0xFF. Program and erase run as multi-cycle sweeps over a synchronous RAM, and `busy_o` is high while a sweep runs. After reset the block runs the same fill sweep over the whole array, so every byte reads 0xFF once `busy_o` falls.

Top module: `nand_page_engine`

## Requirements
- R1: With the default parameters a page holds 64 data bytes followed by a spare area of 64/32 = 2 bytes, so one row is 66 bytes. A read started at column 0 with offset 0 returns exactly 66 array bytes.
- R2: After reset `busy_o` is 1 while the array is filled. Once `busy_o` is 0, every data and spare byte reads 0xFF.
- R3: After `op_prog_i`, a `wr_i` byte is appended to the page buffer only when `cle_i` = 0 and `ale_i` = 0. Bytes that arrive once the buffer holds 66 bytes are dropped.
- R4: `op_commit_i` ANDs buffer byte k into the array byte at column (column + offset + k) of the latched page. Bytes that would land past the end of the row are not written.
- R5: When `wp_n_i` = 0 at the time of `op_commit_i` or `op_erase_i`, the operation has no effect and `busy_o` stays 0.
- R6: `op_erase_i` clears the page number down to a multiple of 4 pages and sets all 4 × 66 bytes of that block to 0xFF.
- R7: Program or erase of a page number of 16 or more has no effect and does not raise `busy_o`. A read of such a page returns 0x00.
- R8: After `op_read_i`, the first data read starts at column plus offset, and the number of readable bytes is 66 minus that start. A start of 66 or more yields no bytes. Once the bytes are used up, reads return 0x00.
- R9: Each data read with `ce_n_i` = 0 returns the next byte and advances. A read with `ce_n_i` = 1 returns 0x00 and does not advance.
- R10: After `op_status_i`, every read returns the status byte, in which bit 7 = `wp_n_i`, bit 6 = ready and all other bits are 0. Status reads never advance the read position.
- R11: `busy_o` is 1 from the cycle after an accepted commit or erase until its sweep ends, and the ready bit reads 0 during that time. Every operation pulse other than `op_status_i` is ignored while `busy_o` is 1.
- R12: Read data appears on `dout_o` in the cycle after the `rd_i` strobe. While the block is idle, that value holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_read_i | input | 1 | Arm a page read at page/column/offset |
| op_prog_i | input | 1 | Clear buffer and latch program target |
| op_commit_i | input | 1 | Commit buffer into the array |
| op_erase_i | input | 1 | Erase the block holding page_i |
| op_status_i | input | 1 | Switch reads to the status byte |
| page_i | input | 5 | Page number |
| col_i | input | 7 | Column within the row |
| off_i | input | 7 | Column offset added to the column |
| ce_n_i | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch phase, blocks data writes |
| ale_i | input | 1 | Address latch phase, blocks data writes |
| wp_n_i | input | 1 | Write protect, active low |
| wr_i | input | 1 | Data write strobe |
| din_i | input | 8 | Write data byte |
| rd_i | input | 1 | Data read strobe |
| dout_o | output | 8 | Read data byte |
| busy_o | output | 1 | Program, erase or initial fill in progress |

## Verification
On every cycle the assertions check four things. The page buffer never grows past one row. A protected or out-of-range commit or erase never raises busy. A status read never moves the read position and reports ready as the inverse of busy. A read with chip enable high yields zero. The AND-only program behaviour, block alignment, clipping at the row end, overflow dropping and the start column of reads can only be shown by the bench's scenarios: it keeps its own model of the array and reads whole pages back after each program and erase.

// File: rtl/nand_pe_pkg.sv
// Package: shared types for the NAND page engine.
// Assumes: one byte-wide array, status layout fixed by the requirements.
package nand_pe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_PRD   = 2'd2,
        ST_PWR   = 2'd3
    } eng_state_t;

    typedef enum logic [1:0] {
        SEL_ZERO   = 2'd0,
        SEL_ARRAY  = 2'd1,
        SEL_STATUS = 2'd2
    } out_sel_t;

    // Status byte: bit 7 unprotected, bit 6 ready, rest zero.
    function automatic logic [7:0] mk_status(input logic unprot, input logic ready);
        return {unprot, ready, 6'b0};
    endfunction

endpackage

// File: rtl/nand_array_ram.sv
// Module: byte-wide synchronous RAM holding all page rows.
// Assumes: one write and one read per cycle; read data is registered and
// holds while re_i is low. Contents are not reset (a fill sweep does that).
module nand_array_ram #(
    parameter int DEPTH = 1056,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        if (re_i) rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/nand_pgbuf.sv
// Module: program page buffer; appends bytes until one row is full.
// Assumes: clr_i and wr_i are not asserted in the same cycle.
module nand_pgbuf #(
    parameter int ROW = 66,
    parameter int CW  = $clog2(ROW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [7:0]    wdata_i,
    input  logic [CW-1:0] ridx_i,
    output logic [7:0]    rdata_o,
    output logic [CW-1:0] len_o
);

    logic [7:0] data_q [ROW];

    // Fill level: cleared on setup, grows by one per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) len_o <= '0;
        else if (wr_i && int'(len_o) < ROW) len_o <= len_o + 1'b1;
    end

    // Byte storage: written at the current fill level.
    always_ff @(posedge clk) begin
        if (wr_i && !clr_i && int'(len_o) < ROW) data_q[len_o] <= wdata_i;
    end

    assign rdata_o = (int'(ridx_i) < ROW) ? data_q[ridx_i] : 8'h00;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(len_o) <= ROW);

endmodule

// File: rtl/nand_page_engine.sv
// Module: NAND page buffer and array engine (top).
// Does: sequential page reads, program gather and AND commit, block erase,
// status reads. Assumes one operation pulse per cycle from the sequencer.
module nand_page_engine
    import nand_pe_pkg::*;
#(
    parameter int PAGE_BYTES    = 64,
    parameter int PAGES_PER_BLK = 4,
    parameter int BLOCKS        = 4,
    localparam int SPARE = PAGE_BYTES / 32,
    localparam int ROW   = PAGE_BYTES + SPARE,
    localparam int PAGES = PAGES_PER_BLK * BLOCKS,
    localparam int DEPTH = PAGES * ROW,
    localparam int MAW   = $clog2(DEPTH),
    localparam int CW    = $clog2(ROW + 1),
    localparam int PW    = $clog2(PAGES) + 1,
    localparam int CNTW  = MAW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_read_i,
    input  logic          op_prog_i,
    input  logic          op_commit_i,
    input  logic          op_erase_i,
    input  logic          op_status_i,
    input  logic [PW-1:0] page_i,
    input  logic [CW-1:0] col_i,
    input  logic [CW-1:0] off_i,
    input  logic          ce_n_i,
    input  logic          cle_i,
    input  logic          ale_i,
    input  logic          wp_n_i,
    input  logic          wr_i,
    input  logic [7:0]    din_i,
    input  logic          rd_i,
    output logic [7:0]    dout_o,
    output logic          busy_o
);

    function automatic logic [MAW-1:0] row_base(input logic [PW-1:0] p);
        return MAW'(p) * MAW'(ROW);
    endfunction

    eng_state_t     st_q;
    logic [CNTW-1:0] cnt_q, lim_q;
    logic [MAW-1:0] base_q;
    logic           rd_mode_q, st_mode_q, prg_mode_q, loaded_q;
    logic [PW-1:0]  page_q;
    logic [CW-1:0]  col_q, off_q, rptr_q, rlen_q;
    out_sel_t       sel_q;
    logic [7:0]     stat_q;

    logic           ram_we, ram_re;
    logic [MAW-1:0] ram_waddr, ram_raddr;
    logic [7:0]     ram_wdata, ram_rdata, buf_rdata;
    logic [CW-1:0]  buf_len;
    logic [CW:0]    start_w, avail_w, climit_w;
    logic           page_ok_in, page_ok_q, rd_fire, load_go, adv_go;
    logic [PW-1:0]  blk_page;

    assign busy_o     = (st_q != ST_IDLE);
    assign page_ok_in = int'(page_i) < PAGES;
    assign page_ok_q  = int'(page_q) < PAGES;
    assign blk_page   = page_i & ~PW'(PAGES_PER_BLK - 1);

    // Start column, room left in the row, and the commit length.
    always_comb begin
        start_w  = {1'b0, col_q} + {1'b0, off_q};
        avail_w  = (int'(start_w) < ROW) ? ((CW+1)'(ROW) - start_w) : '0;
        climit_w = ({1'b0, buf_len} < avail_w) ? {1'b0, buf_len} : avail_w;
    end

    // Data-read decode: first load of a page or advance through it.
    always_comb begin
        rd_fire = rd_i && !st_mode_q && !busy_o && !ce_n_i;
        load_go = rd_fire && rd_mode_q && !loaded_q && page_ok_q && (int'(start_w) < ROW);
        adv_go  = rd_fire && loaded_q && (rlen_q != '0);
    end

    // RAM port steering: sweeps own the ports, idle reads use the read port.
    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_waddr = base_q + MAW'(cnt_q);
        ram_wdata = 8'hFF;
        ram_raddr = row_base(page_q) + MAW'(load_go ? start_w : {1'b0, rptr_q});
        unique case (st_q)
            ST_CLEAR: ram_we = 1'b1;
            ST_PRD: begin
                ram_re    = 1'b1;
                ram_raddr = base_q + MAW'(cnt_q);
            end
            ST_PWR: begin
                ram_we    = 1'b1;
                ram_wdata = ram_rdata & buf_rdata;
            end
            default: ram_re = load_go || adv_go;
        endcase
    end

    // Sweep engine: fill after reset, erase fill, program read-AND-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_CLEAR;
            base_q <= '0;
            cnt_q  <= '0;
            lim_q  <= CNTW'(DEPTH);
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (op_commit_i && prg_mode_q && wp_n_i && page_ok_q && climit_w != '0) begin
                        st_q   <= ST_PRD;
                        base_q <= row_base(page_q) + MAW'(start_w);
                        lim_q  <= CNTW'(climit_w);
                    end else if (op_erase_i && !op_commit_i && wp_n_i && page_ok_in) begin
                        st_q   <= ST_CLEAR;
                        base_q <= row_base(blk_page);
                        lim_q  <= CNTW'(PAGES_PER_BLK * ROW);
                    end
                end
                ST_CLEAR: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == lim_q - 1'b1) st_q <= ST_IDLE;
                end
                ST_PRD: st_q <= ST_PWR;
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    st_q  <= (cnt_q == lim_q - 1'b1) ? ST_IDLE : ST_PRD;
                end
            endcase
        end
    end

    // Mode and read-pointer control driven by operation pulses and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode_q <= 1'b0; st_mode_q <= 1'b0; prg_mode_q <= 1'b0; loaded_q <= 1'b0;
            page_q <= '0; col_q <= '0; off_q <= '0; rptr_q <= '0; rlen_q <= '0;
            sel_q <= SEL_ZERO; stat_q <= '0;
        end else begin
            if (!busy_o) begin
                if (op_read_i) begin
                    rd_mode_q <= 1'b1; st_mode_q <= 1'b0; prg_mode_q <= 1'b0; loaded_q <= 1'b0;
                    page_q <= page_i; col_q <= col_i; off_q <= off_i; rlen_q <= '0;
                end else if (op_prog_i) begin
                    prg_mode_q <= 1'b1; rd_mode_q <= 1'b0; st_mode_q <= 1'b0; loaded_q <= 1'b0;
                    page_q <= page_i; col_q <= col_i; off_q <= off_i;
                end else if (op_commit_i) begin
                    prg_mode_q <= 1'b0;
                end else if (op_erase_i) begin
                    rd_mode_q <= 1'b0; st_mode_q <= 1'b0; prg_mode_q <= 1'b0; loaded_q <= 1'b0;
                end
            end
            if (op_status_i) begin
                st_mode_q <= 1'b1; rd_mode_q <= 1'b0; prg_mode_q <= 1'b0; loaded_q <= 1'b0;
            end
            if (rd_i) begin
                if (st_mode_q) begin
                    sel_q  <= SEL_STATUS;
                    stat_q <= mk_status(wp_n_i, !busy_o);
                end else if (load_go) begin
                    sel_q    <= SEL_ARRAY;
                    loaded_q <= 1'b1;
                    rptr_q   <= CW'(start_w) + 1'b1;
                    rlen_q   <= CW'(avail_w) - 1'b1;
                end else if (adv_go) begin
                    sel_q  <= SEL_ARRAY;
                    rptr_q <= rptr_q + 1'b1;
                    rlen_q <= rlen_q - 1'b1;
                end else begin
                    sel_q <= SEL_ZERO;
                    if (rd_fire && rd_mode_q) loaded_q <= 1'b1;
                end
            end
        end
    end

    assign dout_o = (sel_q == SEL_ARRAY)  ? ram_rdata :
                    (sel_q == SEL_STATUS) ? stat_q : 8'h00;

    nand_array_ram #(.DEPTH(DEPTH), .AW(MAW)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (ram_wdata),
        .re_i    (ram_re),
        .raddr_i (ram_raddr),
        .rdata_o (ram_rdata)
    );

    nand_pgbuf #(.ROW(ROW), .CW(CW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (op_prog_i && !busy_o),
        .wr_i    (wr_i && !cle_i && !ale_i && prg_mode_q && !busy_o),
        .wdata_i (din_i),
        .ridx_i  (CW'(cnt_q)),
        .rdata_o (buf_rdata),
        .len_o   (buf_len)
    );

    assert_wp_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_commit_i || op_erase_i) && !wp_n_i && !busy_o) |=> !busy_o);

    assert_range_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_erase_i && !op_commit_i && !page_ok_in && !busy_o) |=> !busy_o);

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_mode_q) |=> ($stable(rptr_q) && $stable(rlen_q)));

    assert_ready_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_mode_q) |=> (dout_o[6] == !$past(busy_o)));

    assert_ce_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ce_n_i && !st_mode_q) |=> (dout_o == 8'h00));

endmodule

// File: tb/nand_page_engine_tb.sv
module nand_page_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROW   = 66;
    localparam int PAGES = 16;
    localparam int PPB   = 4;

    typedef struct packed {
        int kind;   // 0 program, 1 erase
        int page;
        int col;
        int off;
        int n;
        int seed;
        int wp;
        int req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{0, 1,  0,  0, 66, 8'h5A, 1, 4},  // R4 full row incl. spare
        '{0, 1, 10,  0,  8, 8'h0F, 1, 4},  // R4 AND over existing data
        '{0, 2,  0, 64,  2, 8'h12, 1, 1},  // R1 spare bytes via offset
        '{0, 3,  0,  0, 70, 8'hC3, 1, 3},  // R3 overflow dropped
        '{0, 5, 60,  0, 20, 8'h00, 1, 4},  // R4 clipped at row end
        '{0, 6,  0,  0, 10, 8'h00, 0, 5},  // R5 protected program
        '{0, 4,  0,  0, 30, 8'h21, 1, 4},  // R4
        '{0, 7,  0,  0, 30, 8'h44, 1, 4},  // R4
        '{1, 6,  0,  0,  0, 0,     0, 5},  // R5 protected erase
        '{1, 6,  0,  0,  0, 0,     1, 6},  // R6 erase aligns to pages 4..7
        '{0, 20, 0,  0,  5, 8'h00, 1, 7},  // R7 program out of range
        '{1, 17, 0,  0,  0, 0,     1, 7}   // R7 erase out of range
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_read_i = 0, op_prog_i = 0, op_commit_i = 0, op_erase_i = 0, op_status_i = 0;
    logic [4:0] page_i = '0;
    logic [6:0] col_i = '0, off_i = '0;
    logic ce_n_i = 0, cle_i = 0, ale_i = 0, wp_n_i = 1, wr_i = 0, rd_i = 0;
    logic [7:0] din_i = '0;
    logic [7:0] dout_o;
    logic busy_o;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] mdl [PAGES][ROW];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_page_engine dut_i (
        .clk(clk), .rst_n(rst_n), .op_read_i(op_read_i), .op_prog_i(op_prog_i),
        .op_commit_i(op_commit_i), .op_erase_i(op_erase_i), .op_status_i(op_status_i),
        .page_i(page_i), .col_i(col_i), .off_i(off_i), .ce_n_i(ce_n_i), .cle_i(cle_i),
        .ale_i(ale_i), .wp_n_i(wp_n_i), .wr_i(wr_i), .din_i(din_i), .rd_i(rd_i),
        .dout_o(dout_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_addr(input int p, input int c, input int o);
        page_i = 5'(p); col_i = 7'(c); off_i = 7'(o);
    endtask

    task automatic pulse_read();   op_read_i = 1;   @(negedge clk); op_read_i = 0;   endtask
    task automatic pulse_prog();   op_prog_i = 1;   @(negedge clk); op_prog_i = 0;   endtask
    task automatic pulse_commit(); op_commit_i = 1; @(negedge clk); op_commit_i = 0; endtask
    task automatic pulse_erase();  op_erase_i = 1;  @(negedge clk); op_erase_i = 0;  endtask
    task automatic pulse_status(); op_status_i = 1; @(negedge clk); op_status_i = 0; endtask

    task automatic rd_byte(output logic [7:0] v);
        rd_i = 1; @(negedge clk); rd_i = 0; v = dout_o;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        din_i = d; wr_i = 1; @(negedge clk); wr_i = 0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    // Reads a whole row plus one extra byte and compares with the model.
    task automatic verify_page(input int p, input string req);
        logic [7:0] v;
        int bad = -1;
        logic [7:0] bad_act = 0;
        set_addr(p, 0, 0);
        pulse_read();
        for (int k = 0; k < ROW; k++) begin
            rd_byte(v);
            if (v !== mdl[p][k] && bad < 0) begin bad = k; bad_act = v; end
        end
        check(bad < 0, req, $sformatf("page %0d byte %0d", p, bad), bad_act,
              (bad < 0) ? 0 : mdl[p][bad]);
        rd_byte(v);
        check(v == 8'h00, "R8", $sformatf("page %0d read past row", p), v, 0);
    endtask

    task automatic apply_vec(input vec_t t);
        int start, taken, cnt;
        bit effect;
        string req;
        req = $sformatf("R%0d", t.req);
        wp_n_i = t.wp[0];
        set_addr(t.page, t.col, t.off);
        start = t.col + t.off;
        if (t.kind == 0) begin
            pulse_prog();
            for (int k = 0; k < t.n; k++) wr_byte(8'(t.seed + 3 * k));
            taken = (t.n < ROW) ? t.n : ROW;
            cnt = (start < ROW) ? ((taken < ROW - start) ? taken : ROW - start) : 0;
            effect = t.wp != 0 && t.page < PAGES && cnt > 0;
            pulse_commit();
            if (effect)
                for (int k = 0; k < cnt; k++) mdl[t.page][start + k] &= 8'(t.seed + 3 * k);
        end else begin
            effect = t.wp != 0 && t.page < PAGES;
            pulse_erase();
            if (effect)
                for (int pg = (t.page / PPB) * PPB; pg < (t.page / PPB) * PPB + PPB; pg++)
                    for (int k = 0; k < ROW; k++) mdl[pg][k] = 8'hFF;
        end
        // R11 busy after accepted operation, R5/R7 no busy when ignored
        check(busy_o == effect, effect ? "R11" : req, "busy after operation", busy_o, effect);
        wait_idle();
        wp_n_i = 1;
    endtask

    initial begin
        logic [7:0] v;
        for (int p = 0; p < PAGES; p++) for (int k = 0; k < ROW; k++) mdl[p][k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy_o == 1'b1, "R2", "busy during initial fill", busy_o, 1);
        check(dout_o == 8'h00, "R12", "dout after reset", dout_o, 0);
        wait_idle();
        verify_page(0, "R2");
        verify_page(15, "R1");

        // R10 status reads repeat without advancing
        wp_n_i = 1;
        pulse_status();
        for (int i = 0; i < 3; i++) begin
            rd_byte(v);
            check(v == 8'hC0, "R10", "status unprotected", v, 8'hC0);
        end
        wp_n_i = 0;
        rd_byte(v);
        check(v == 8'h40, "R10", "status protected", v, 8'h40);
        wp_n_i = 1;

        // Table walk: each vector then a full read-back of every page
        for (int i = 0; i < NV; i++) begin
            apply_vec(VECS[i]);
            for (int p = 0; p < PAGES; p++) verify_page(p, $sformatf("R%0d", VECS[i].req));
        end

        // R3 bytes with cle or ale high are not gathered
        set_addr(8, 0, 0);
        pulse_prog();
        wr_byte(8'h11);
        cle_i = 1; wr_byte(8'h00); cle_i = 0;
        ale_i = 1; wr_byte(8'h00); ale_i = 0;
        wr_byte(8'h22);
        pulse_commit();
        wait_idle();
        mdl[8][0] = 8'h11; mdl[8][1] = 8'h22;
        verify_page(8, "R3");

        // R8 read start at column plus offset, then exhausted
        set_addr(1, 3, 60);
        pulse_read();
        for (int k = 63; k < ROW; k++) begin
            rd_byte(v);
            check(v == mdl[1][k], "R8", $sformatf("col+off byte %0d", k), v, mdl[1][k]);
        end
        rd_byte(v);
        check(v == 8'h00, "R8", "after short read", v, 0);

        // R12 idle hold of the last read byte
        set_addr(1, 0, 0);
        pulse_read();
        rd_byte(v);
        repeat (3) @(negedge clk);
        check(dout_o == mdl[1][0], "R12", "held read data", dout_o, mdl[1][0]);

        // R9 chip enable high gives zero and does not advance
        ce_n_i = 1; rd_byte(v); ce_n_i = 0;
        check(v == 8'h00, "R9", "read with ce_n high", v, 0);
        rd_byte(v);
        check(v == mdl[1][1], "R9", "next byte after ce_n high", v, mdl[1][1]);

        // R8 start beyond row yields nothing
        set_addr(1, 10, 64);
        pulse_read();
        rd_byte(v);
        check(v == 8'h00, "R8", "start beyond row", v, 0);

        // R7 read of out-of-range page
        set_addr(20, 0, 0);
        pulse_read();
        rd_byte(v);
        check(v == 8'h00, "R7", "out-of-range page read", v, 0);

        // R11 status during erase, other operations ignored while busy
        set_addr(0, 0, 0);
        pulse_erase();
        for (int pg = 0; pg < PPB; pg++) for (int k = 0; k < ROW; k++) mdl[pg][k] = 8'hFF;
        check(busy_o == 1'b1, "R11", "busy after erase", busy_o, 1);
        pulse_status();
        rd_byte(v);
        check(v == 8'h80, "R11", "status while busy", v, 8'h80);
        set_addr(8, 0, 0);
        pulse_erase();
        wait_idle();
        rd_byte(v);
        check(v == 8'hC0, "R11", "status after erase", v, 8'hC0);
        verify_page(1, "R6");
        verify_page(8, "R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule